// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside the fetch stage of a 32-bit RISC core and decides when the core leaves its normal instruction stream. It watches two asynchronous sources, an external interrupt line and a tick timer line, together with a synchronous exception request that the pipeline raises with an exception index. It also watches a return-from-exception strobe. In any cycle it picks at most one of these events.

On entry it saves the status word and a return address, and it places the core in supervisor mode with translation and both interrupt sources disabled. It then sends the fetch stage a vector address. On return it restores the status word and redirects fetch to the saved address. Each entry asks for a flush of the translation buffers. A return asks for one only when the privilege or translation bits change.

The redirect is a plain one-cycle pulse with no back-pressure. The request inputs are levels that the pipeline holds until it sees the redirect pulse or the error pulse. The cycle that follows a pulse is a busy cycle, and the block acts on no input during it. Software writes the status word through a simple write strobe.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the status word is 0x00000001 (supervisor bit only), the saved status and saved PC are zero, and the redirect, error, flush and slot-clear pulses are low.
- R2: Status bit positions are SM=0, TEE=1, IEE=2, DME=5, IME=6, DSX=13. An external interrupt is taken only when IEE is set, and a tick only when TEE is set. If both are taken at once the tick wins and the vector is 0x500. The external interrupt vector is 0x800.
- R3: Priority, from highest to lowest, is return strobe, synchronous exception, tick, external interrupt. A request seen in the same cycle as a return is acted on after the return's busy cycle, provided it is still held.
- R4: An entry raises the redirect pulse one clock after the request, and the redirect address is the exception index shifted left by 8.
- R5: A synchronous index of 0 or of 15 and above raises a one-cycle error pulse. In that case there is no redirect, and the status, saved status and saved PC do not change.
- R6: Outside a delay slot, indices 0x5, 0x8, 0xC and 0xD save the next PC. Every other index saves the current PC.
- R7: Inside a delay slot, indices 0x5, 0x8, 0xC and 0xD save the branch target, and every other index saves the current PC minus 4. The entry also sets DSX and pulses the slot-clear output.
- R8: On entry the saved status takes the old status word. The new status clears DME, IME, IEE and TEE, sets SM, and keeps every other bit. DSX is left alone outside a slot.
- R9: On return the redirect address is the saved PC, and the status word is loaded from the saved status.
- R10: Every entry pulses the flush output together with the redirect. A return pulses it only if SM, IME or DME differ between the status and the saved status.
- R11: The redirect pulse lasts exactly one cycle. Requests present during the following busy cycle are not acted on.
- R12: A status write loads the status word in a cycle where no entry, return or error is selected. In a cycle where one is selected, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | 1 | External interrupt request level |
| tick_irq_i | input | 1 | Tick timer request level |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_idx_i | input | 4 | Synchronous exception index |
| pc_i | input | 32 | PC of the interrupted instruction |
| npc_i | input | 32 | Next sequential PC |
| jmp_pc_i | input | 32 | Branch target of the pending branch |
| dslot_i | input | 1 | Interrupted instruction sits in a delay slot |
| rfe_i | input | 1 | Return-from-exception strobe |
| sr_we_i | input | 1 | Status word write strobe |
| sr_wdata_i | input | 32 | Status word write data |
| redir_valid_o | output | 1 | One-cycle fetch redirect pulse |
| redir_pc_o | output | 32 | Redirect address (PC and next PC) |
| dslot_clr_o | output | 1 | Pulse: clear the core's delay-slot flag |
| bad_idx_o | output | 1 | Pulse: illegal synchronous index |
| tlb_flush_o | output | 1 | Pulse: flush translation buffers |
| sr_o | output | 32 | Status word |
| esr_o | output | 32 | Saved status word |
| epcr_o | output | 32 | Saved return PC |

## Verification
The embedded properties check the following on every cycle: that the redirect pulse is a single cycle, that every entry carries a flush and an aligned vector with the supervisor mode bits forced, that an error pulse never comes with a redirect or a state change, that a return restores the saved status, and that a return without a flush left the mode bits unchanged. Only the bench scenarios can show the rest, because it concerns the choice among events and the address values. That covers which source wins when several are present, the four return-address cases, the deferral of a request that arrives with a return, and a status write being dropped during an entry.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN      = 32;
  localparam int IDX_W     = 4;
  localparam int VEC_SHIFT = 8;
  localparam int NUM_EXC   = 15;

  // status bit positions
  localparam int SR_SM  = 0;
  localparam int SR_TEE = 1;
  localparam int SR_IEE = 2;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_DSX = 13;

  localparam logic [IDX_W-1:0] IDX_TICK = 4'h5;
  localparam logic [IDX_W-1:0] IDX_EXT  = 4'h8;
  localparam logic [IDX_W-1:0] IDX_SYS  = 4'hC;
  localparam logic [IDX_W-1:0] IDX_FPE  = 4'hD;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_RFE,
    ACT_SYNC,
    ACT_TICK,
    ACT_EXT
  } act_e;

  // classes whose return resumes after the faulting point
  function automatic logic saves_next(input logic [IDX_W-1:0] idx);
    return (idx == IDX_TICK) || (idx == IDX_EXT) ||
           (idx == IDX_SYS)  || (idx == IDX_FPE);
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int IW   = IDX_W,
  parameter int NEXC = NUM_EXC
) (
  input  logic          busy_i,
  input  logic          rfe_i,
  input  logic          exc_req_i,
  input  logic [IW-1:0] exc_idx_i,
  input  logic          tick_i,
  input  logic          tick_en_i,
  input  logic          ext_i,
  input  logic          ext_en_i,
  output act_e          act_o,
  output logic [IW-1:0] idx_o,
  output logic          bad_o
);
  always_comb begin
    act_o = ACT_NONE;
    idx_o = exc_idx_i;
    if (!busy_i) begin
      if (rfe_i) begin
        act_o = ACT_RFE;
      end else if (exc_req_i) begin
        act_o = ACT_SYNC;
      end else if (tick_i && tick_en_i) begin
        act_o = ACT_TICK;
        idx_o = IW'(IDX_TICK);
      end else if (ext_i && ext_en_i) begin
        act_o = ACT_EXT;
        idx_o = IW'(IDX_EXT);
      end
    end
  end

  assign bad_o = (act_o == ACT_SYNC) &&
                 ((exc_idx_i == '0) || (int'(exc_idx_i) >= NEXC));
endmodule

// File: rtl/trap_retaddr.sv
module trap_retaddr
  import trap_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IDX_W
) (
  input  logic [IW-1:0] idx_i,
  input  logic          dslot_i,
  input  logic [W-1:0]  pc_i,
  input  logic [W-1:0]  npc_i,
  input  logic [W-1:0]  jmp_i,
  output logic [W-1:0]  epc_o
);
  localparam logic [W-1:0] INSN_BYTES = W'(4);

  logic resume_after;
  assign resume_after = saves_next(IDX_W'(idx_i));

  always_comb begin
    unique case ({dslot_i, resume_after})
      2'b11:   epc_o = jmp_i;
      2'b10:   epc_o = pc_i - INSN_BYTES;
      2'b01:   epc_o = npc_i;
      default: epc_o = pc_i;
    endcase
  end
endmodule

// File: rtl/trap_csr.sv
module trap_csr
  import trap_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         entry_i,
  input  logic         ret_i,
  input  logic         dslot_i,
  input  logic [W-1:0] epc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] esr_o,
  output logic [W-1:0] epcr_o,
  output logic         ret_flush_o
);
  localparam logic [W-1:0] SM_BIT    = W'(1) << SR_SM;
  localparam logic [W-1:0] DSX_BIT   = W'(1) << SR_DSX;
  localparam logic [W-1:0] CLR_MASK  = (W'(1) << SR_DME) | (W'(1) << SR_IME) |
                                       (W'(1) << SR_IEE) | (W'(1) << SR_TEE);
  localparam logic [W-1:0] MODE_MASK = SM_BIT | (W'(1) << SR_DME) | (W'(1) << SR_IME);
  localparam logic [W-1:0] SR_RST    = SM_BIT;

  logic [W-1:0] sr_q, esr_q, epcr_q, entry_sr;

  assign entry_sr    = (sr_q & ~CLR_MASK) | SM_BIT | (dslot_i ? DSX_BIT : '0);
  assign ret_flush_o = ((sr_q ^ esr_q) & MODE_MASK) != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= SR_RST;
      esr_q  <= '0;
      epcr_q <= '0;
    end else if (entry_i) begin
      esr_q  <= sr_q;
      sr_q   <= entry_sr;
      epcr_q <= epc_i;
    end else if (ret_i) begin
      sr_q <= esr_q;
    end else if (wr_i) begin
      sr_q <= wdata_i;
    end
  end

  assign sr_o   = sr_q;
  assign esr_o  = esr_q;
  assign epcr_o = epcr_q;

  // R8
  entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i |=> esr_q == $past(sr_q));
  // R9
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> sr_q == $past(esr_q));
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_irq_i,
  input  logic          tick_irq_i,
  input  logic          exc_req_i,
  input  logic [IW-1:0] exc_idx_i,
  input  logic [W-1:0]  pc_i,
  input  logic [W-1:0]  npc_i,
  input  logic [W-1:0]  jmp_pc_i,
  input  logic          dslot_i,
  input  logic          rfe_i,
  input  logic          sr_we_i,
  input  logic [W-1:0]  sr_wdata_i,
  output logic          redir_valid_o,
  output logic [W-1:0]  redir_pc_o,
  output logic          dslot_clr_o,
  output logic          bad_idx_o,
  output logic          tlb_flush_o,
  output logic [W-1:0]  sr_o,
  output logic [W-1:0]  esr_o,
  output logic [W-1:0]  epcr_o
);
  localparam int PAD_W = W - IW - VEC_SHIFT;
  localparam logic [W-1:0] MODE_MASK = (W'(1) << SR_SM) | (W'(1) << SR_DME) |
                                       (W'(1) << SR_IME);

  act_e          act;
  logic [IW-1:0] idx;
  logic          bad, busy, take_entry, take_ret, ret_flush;
  logic [W-1:0]  epc, vec;
  logic          redir_q, bad_q, ret_q, flush_q, dclr_q;
  logic [W-1:0]  redir_pc_q;

  assign busy = redir_q | bad_q;

  trap_arbiter #(.IW(IW), .NEXC(NUM_EXC)) u_arb (
    .busy_i    (busy),
    .rfe_i     (rfe_i),
    .exc_req_i (exc_req_i),
    .exc_idx_i (exc_idx_i),
    .tick_i    (tick_irq_i),
    .tick_en_i (sr_o[SR_TEE]),
    .ext_i     (ext_irq_i),
    .ext_en_i  (sr_o[SR_IEE]),
    .act_o     (act),
    .idx_o     (idx),
    .bad_o     (bad)
  );

  trap_retaddr #(.W(W), .IW(IW)) u_ret (
    .idx_i   (idx),
    .dslot_i (dslot_i),
    .pc_i    (pc_i),
    .npc_i   (npc_i),
    .jmp_i   (jmp_pc_i),
    .epc_o   (epc)
  );

  assign take_entry = (act == ACT_SYNC || act == ACT_TICK || act == ACT_EXT) && !bad;
  assign take_ret   = (act == ACT_RFE);
  assign vec        = {{PAD_W{1'b0}}, idx, {VEC_SHIFT{1'b0}}};

  trap_csr #(.W(W)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_i     (take_entry),
    .ret_i       (take_ret),
    .dslot_i     (dslot_i),
    .epc_i       (epc),
    .wr_i        (sr_we_i && act == ACT_NONE),
    .wdata_i     (sr_wdata_i),
    .sr_o        (sr_o),
    .esr_o       (esr_o),
    .epcr_o      (epcr_o),
    .ret_flush_o (ret_flush)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_q    <= 1'b0;
      bad_q      <= 1'b0;
      ret_q      <= 1'b0;
      flush_q    <= 1'b0;
      dclr_q     <= 1'b0;
      redir_pc_q <= '0;
    end else begin
      redir_q <= take_entry | take_ret;
      bad_q   <= bad;
      ret_q   <= take_ret;
      flush_q <= take_entry | (take_ret & ret_flush);
      dclr_q  <= take_entry & dslot_i;
      if (take_entry)    redir_pc_q <= vec;
      else if (take_ret) redir_pc_q <= epcr_o;
    end
  end

  assign redir_valid_o = redir_q;
  assign redir_pc_o    = redir_pc_q;
  assign bad_idx_o     = bad_q;
  assign tlb_flush_o   = flush_q;
  assign dslot_clr_o   = dclr_q;

  // R11
  redir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_o |=> !redir_valid_o);
  // R10
  entry_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && !ret_q) |-> tlb_flush_o);
  // R4
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && !ret_q) |-> (redir_pc_o[VEC_SHIFT-1:0] == '0));
  // R8
  entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && !ret_q) |-> (sr_o[SR_SM] && !sr_o[SR_IEE] && !sr_o[SR_TEE] &&
                                   !sr_o[SR_DME] && !sr_o[SR_IME]));
  // R5
  bad_no_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_idx_o |-> !redir_valid_o);
  // R5
  bad_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_idx_o |-> ($stable(sr_o) && $stable(esr_o) && $stable(epcr_o)));
  // R10
  ret_noflush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_o && ret_q && !tlb_flush_o) |-> ((sr_o & MODE_MASK) == ($past(sr_o) & MODE_MASK)));
endmodule

// File: tb/tb_trap_sequencer.sv
module tb_trap_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_irq_i = 0, tick_irq_i = 0, exc_req_i = 0, dslot_i = 0, rfe_i = 0, sr_we_i = 0;
  logic [3:0]  exc_idx_i = '0;
  logic [31:0] pc_i = 32'h1000, npc_i = 32'h1004, jmp_pc_i = 32'h2000, sr_wdata_i = '0;
  logic        redir_valid_o, dslot_clr_o, bad_idx_o, tlb_flush_o;
  logic [31:0] redir_pc_o, sr_o, esr_o, epcr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trap_sequencer dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq_i), .tick_irq_i(tick_irq_i),
    .exc_req_i(exc_req_i), .exc_idx_i(exc_idx_i), .pc_i(pc_i), .npc_i(npc_i),
    .jmp_pc_i(jmp_pc_i), .dslot_i(dslot_i), .rfe_i(rfe_i), .sr_we_i(sr_we_i),
    .sr_wdata_i(sr_wdata_i), .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
    .dslot_clr_o(dslot_clr_o), .bad_idx_o(bad_idx_o), .tlb_flush_o(tlb_flush_o),
    .sr_o(sr_o), .esr_o(esr_o), .epcr_o(epcr_o)
  );

  typedef struct packed {
    logic [15:0] sr0;
    logic        ext;
    logic        tick;
    logic        exc;
    logic [3:0]  idx;
    logic        dslot;
    logic        take;
    logic [15:0] exp_pc;
    logic [15:0] exp_epc;
    logic [15:0] exp_sr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0006, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 16'h0800, 16'h1004, 16'h0001},
    '{16'h0066, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 16'h0500, 16'h1004, 16'h0001},
    '{16'h0002, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 16'h0500, 16'h1004, 16'h0001},
    '{16'h0004, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 16'h0800, 16'h1004, 16'h0001},
    '{16'h0060, 1'b0, 1'b0, 1'b1, 4'hC, 1'b1, 1'b1, 16'h0C00, 16'h2000, 16'h2001},
    '{16'h0100, 1'b0, 1'b0, 1'b1, 4'h3, 1'b1, 1'b1, 16'h0300, 16'h0FFC, 16'h2101},
    '{16'h0100, 1'b0, 1'b0, 1'b1, 4'h2, 1'b0, 1'b1, 16'h0200, 16'h1000, 16'h0101},
    '{16'h0006, 1'b1, 1'b1, 1'b1, 4'hD, 1'b0, 1'b1, 16'h0D00, 16'h1004, 16'h0001},
    '{16'h0000, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000},
    '{16'h0002, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0002},
    '{16'h0000, 1'b0, 1'b0, 1'b1, 4'hD, 1'b1, 1'b1, 16'h0D00, 16'h2000, 16'h2001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_sr(input logic [31:0] v);
    @(negedge clk);
    sr_we_i = 1'b1;
    sr_wdata_i = v;
    @(negedge clk);
    sr_we_i = 1'b0;
    check("R12 status write", sr_o, v);
  endtask

  task automatic clear_req();
    ext_irq_i = 0; tick_irq_i = 0; exc_req_i = 0; rfe_i = 0; dslot_i = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] esr_keep, epc_keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sr", sr_o, 32'h1);
    check("R1 esr", esr_o, 32'h0);
    check("R1 epcr", epcr_o, 32'h0);
    check("R1 pulses", {28'h0, redir_valid_o, bad_idx_o, tlb_flush_o, dslot_clr_o}, 32'h0);

    // table walk: R2 R3 R4 R6 R7 R8 R10 R11
    for (int i = 0; i < NV; i++) begin
      write_sr({16'h0, VECS[i].sr0});
      ext_irq_i = VECS[i].ext; tick_irq_i = VECS[i].tick; exc_req_i = VECS[i].exc;
      exc_idx_i = VECS[i].idx; dslot_i = VECS[i].dslot;
      @(negedge clk);
      check("R2 taken", {31'h0, redir_valid_o}, {31'h0, VECS[i].take});
      check("R8 sr", sr_o, {16'h0, VECS[i].exp_sr});
      if (VECS[i].take) begin
        check("R4 vector", redir_pc_o, {16'h0, VECS[i].exp_pc});
        check(VECS[i].dslot ? "R7 epcr" : "R6 epcr", epcr_o, {16'h0, VECS[i].exp_epc});
        check("R8 esr", esr_o, {16'h0, VECS[i].sr0});
        check("R10 entry flush", {31'h0, tlb_flush_o}, 32'h1);
        check("R7 slot clear", {31'h0, dslot_clr_o}, {31'h0, VECS[i].dslot});
      end
      clear_req();
      @(negedge clk);
      check("R11 single pulse", {31'h0, redir_valid_o}, 32'h0);
    end

    // R5 illegal indices
    write_sr(32'h0066);
    esr_keep = esr_o;
    epc_keep = epcr_o;
    for (int k = 0; k < 2; k++) begin
      exc_req_i = 1'b1;
      exc_idx_i = (k == 0) ? 4'hF : 4'h0;
      @(negedge clk);
      check("R5 error pulse", {31'h0, bad_idx_o}, 32'h1);
      check("R5 no redirect", {31'h0, redir_valid_o}, 32'h0);
      check("R5 sr kept", sr_o, 32'h0066);
      check("R5 esr kept", esr_o, esr_keep);
      check("R5 epcr kept", epcr_o, epc_keep);
      clear_req();
      @(negedge clk);
    end

    // R9 R10 return with mode change
    exc_req_i = 1'b1; exc_idx_i = 4'hC;
    @(negedge clk);
    clear_req();
    @(negedge clk);
    check("R8 esr before return", esr_o, 32'h0066);
    rfe_i = 1'b1;
    @(negedge clk);
    check("R9 return target", redir_pc_o, 32'h1004);
    check("R9 status restored", sr_o, 32'h0066);
    check("R10 return flush on mode change", {31'h0, tlb_flush_o}, 32'h1);
    clear_req();
    @(negedge clk);
    // R10 return with no mode change; R3 request deferred behind return
    rfe_i = 1'b1; ext_irq_i = 1'b1;
    @(negedge clk);
    check("R3 return first", {redir_pc_o[30:0], redir_valid_o}, {31'h1004, 1'b1});
    check("R10 no flush", {31'h0, tlb_flush_o}, 32'h0);
    rfe_i = 1'b0;
    @(negedge clk);
    check("R11 busy cycle ignores request", {31'h0, redir_valid_o}, 32'h0);
    @(negedge clk);
    check("R3 deferred request taken", {redir_pc_o[30:0], redir_valid_o}, {31'h800, 1'b1});
    clear_req();
    @(negedge clk);

    // R12 write dropped during entry
    write_sr(32'h0004);
    ext_irq_i = 1'b1; sr_we_i = 1'b1; sr_wdata_i = 32'hFFFF0000;
    @(negedge clk);
    sr_we_i = 1'b0;
    clear_req();
    check("R12 write dropped on entry", sr_o, 32'h0001);
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule